// File: doc/BRIEF.md
# TDM Audio Port DMA Request Generator

This block sits beside the shift logic of a multichannel time-division-multiplexed audio serial port. It raises the DMA requests that keep the port's serializer buffers filled on the transmit side and emptied on the receive side. A slot counter follows the frame. It restarts at zero on each frame-sync pulse and advances on each slot tick. At every slot boundary, each active serializer of a direction marks its buffer as needing service. One request per direction then covers every active serializer of that direction. Any transmit-buffer write or receive-buffer read clears the matching ready flag, whatever its source, and that includes a debug access.

Each direction has its own request scheme. In the combined scheme, every request appears on a single line. In the split scheme, requests go out on an even line or an odd line, chosen by the parity of the slot the data belongs to. A transmit request asks for the data of the slot after the one now starting. A receive request asks for the data of the slot that has just ended. DMA requests need no enable. CPU interrupts are a separate path and are gated by an enable register. A sticky error flag per direction records a slot boundary that arrived before the previous request was serviced.

Configuration and status pass through a small register port. Writes are strobed and reads are combinational. Register addresses: 0 scheme control, 1 interrupt enables, 2 slots per frame, 3 active-serializer masks, 4 error status, 5 current slot, 6 ready flags.

Top module: `tdm_dma_event_gen`

## Requirements
- R1: The slot counter, read at address 5, resets to 0. It goes to 0 on any cycle with `fsync_i` high. On a `slot_tick_i` without frame sync it advances by one, and it wraps to 0 from slots-per-frame minus one. Slots per frame is held at address 2 and resets to all ones.
- R2: At each boundary (frame sync or slot tick), every serializer whose bit is set in the active mask has its ready flag set. Address 3 holds the transmit mask in bits [N_SER-1:0] and the receive mask in bits [2*N_SER-1:N_SER]. A `tx_buf_wr_i` or `rx_buf_rd_i` strobe clears that serializer's flag. A set at a boundary takes priority over a clear in the same cycle. Address 6 reads the transmit flags in bits [N_SER-1:0] and the receive flags above them.
- R3: A direction's request is a one-cycle pulse in the cycle after the boundary. It is raised only when the active mask is nonzero and every active flag is set. With an empty mask, no request appears.
- R4: With a direction's scheme bit at 0 (combined), its request appears on `*_dma_o` and its even and odd lines stay low. Address 0 bit 0 selects the transmit scheme and bit 1 the receive scheme.
- R5: With the scheme bit at 1 (split), the combined line stays low. The request goes to the even line when the parity slot is even and to the odd line otherwise. For transmit, the parity slot is the slot after the newly current one, counted with wrap. For receive, it is the slot that just ended.
- R6: The two directions' schemes are set independently, and each direction follows only its own bit.
- R7: For one direction, no more than one of the combined, even and odd lines is high at any time.
- R8: DMA requests appear with every interrupt enable bit at 0.
- R9: `tx_irq_o` = (enable bit 0 and a transmit request) or (enable bit 1 and the transmit error flag). `rx_irq_o` uses enable bits 2 and 3 in the same way. The enable register is at address 1.
- R10: At a boundary, if any active flag of a direction is still set and is not being cleared in that cycle, that direction's error flag is set. Address 4 bit 0 is the transmit error and bit 1 the receive error. Writing a 1 clears the flag, and a set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame-sync pulse, starts slot 0 |
| slot_tick_i | input | 1 | Slot boundary pulse |
| tx_buf_wr_i | input | N_SER | Per-serializer transmit buffer write strobe |
| rx_buf_rd_i | input | N_SER | Per-serializer receive buffer read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| tx_dma_o | output | 1 | Transmit request, combined scheme |
| tx_dma_even_o | output | 1 | Transmit request, even slot |
| tx_dma_odd_o | output | 1 | Transmit request, odd slot |
| rx_dma_o | output | 1 | Receive request, combined scheme |
| rx_dma_even_o | output | 1 | Receive request, even slot |
| rx_dma_odd_o | output | 1 | Receive request, odd slot |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
The bench instantiates the block with N_SER=3, SLOT_W=3 and DATA_W=16, then programs five slots per frame. An odd frame length lets the bench check a wrap from slot 4 to slot 0, where two even slots come in a row, for both the receive previous-slot parity and the transmit next-slot parity. It also checks a frame sync that arrives mid-frame. Each mask leaves one serializer inactive. This shows that strobes to inactive serializers do no harm, and that a single partial debug read leaves the remaining flag visible at address 6. The 16-bit data path keeps the combined mask field and the error bits inside the word, so the field positions are checked directly.

// File: rtl/tdm_dma_pkg.sv
package tdm_dma_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] RA_IEN  = 3'd1;
   localparam logic [ADDR_W-1:0] RA_SPF  = 3'd2;
   localparam logic [ADDR_W-1:0] RA_MASK = 3'd3;
   localparam logic [ADDR_W-1:0] RA_STAT = 3'd4;
   localparam logic [ADDR_W-1:0] RA_SLOT = 3'd5;
   localparam logic [ADDR_W-1:0] RA_RDY  = 3'd6;

   typedef enum logic {
      EV_COMBINED = 1'b0,
      EV_SPLIT    = 1'b1
   } ev_scheme_e;

   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int N_DIR  = 2;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic              tick_i,
   input  logic [SLOT_W-1:0] spf_i,
   output logic              bnd_o,
   output logic [SLOT_W-1:0] cur_o,
   output logic [SLOT_W-1:0] ahead_o
);
   localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

   logic [SLOT_W-1:0] slot_q, slot_d, last_slot;

   assign last_slot = spf_i - ONE;

   function automatic logic [SLOT_W-1:0] wrap_inc(input logic [SLOT_W-1:0] v,
                                                  input logic [SLOT_W-1:0] last);
      return (v >= last) ? '0 : v + ONE;
   endfunction

   assign bnd_o   = fsync_i | tick_i;
   assign slot_d  = fsync_i ? '0 : wrap_inc(slot_q, last_slot);
   assign ahead_o = wrap_inc(slot_d, last_slot);
   assign cur_o   = slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     slot_q <= '0;
      else if (bnd_o) slot_q <= slot_d;
   end

   assert_fsync_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_i |=> (cur_o == '0));
   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !fsync_i && (cur_o >= last_slot)) |=> (cur_o == '0));
endmodule

// File: rtl/tdm_dir_tracker.sv
module tdm_dir_tracker #(
   parameter int N_SER = 4,
   parameter int IS_RX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd_i,
   input  logic             prev_par_i,
   input  logic             ahead_par_i,
   input  logic [N_SER-1:0] act_i,
   input  logic [N_SER-1:0] acc_i,
   input  logic             err_clr_i,
   output logic             fire_o,
   output logic             par_o,
   output logic [N_SER-1:0] rdy_o,
   output logic             err_o
);
   logic [N_SER-1:0] rdy_q, left_over;
   logic             armed_q, par_q, err_q, par_src, par_unused;

   generate
      if (IS_RX != 0) begin : g_prev_slot
         assign par_src    = prev_par_i;
         assign par_unused = ahead_par_i;
      end else begin : g_next_slot
         assign par_src    = ahead_par_i;
         assign par_unused = prev_par_i;
      end
   endgenerate

   assign left_over = rdy_q & ~acc_i & act_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q   <= '0;
         armed_q <= 1'b0;
         par_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         rdy_q   <= (rdy_q & ~acc_i) | (bnd_i ? act_i : '0);
         armed_q <= bnd_i && (act_i != '0);
         if (bnd_i) par_q <= par_src;
         if (bnd_i && (left_over != '0)) err_q <= 1'b1;
         else if (err_clr_i)              err_q <= 1'b0;
      end
   end

   assign fire_o = armed_q && ((rdy_q & act_i) == act_i);
   assign par_o  = par_q;
   assign rdy_o  = rdy_q;
   assign err_o  = err_q;

   assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (!fire_o || $past(bnd_i)));
   assert_after_bnd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(bnd_i));
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_i != '0) && !bnd_i) |=> ((rdy_o & $past(acc_i)) == '0));
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !err_clr_i) |=> err_o);
endmodule

// File: rtl/tdm_dma_event_gen.sv
module tdm_dma_event_gen
   import tdm_dma_pkg::*;
#(
   parameter int N_SER  = 4,
   parameter int SLOT_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic              slot_tick_i,
   input  logic [N_SER-1:0]  tx_buf_wr_i,
   input  logic [N_SER-1:0]  rx_buf_rd_i,
   input  logic              reg_wr_i,
   input  logic [2:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              tx_dma_o,
   output logic              tx_dma_even_o,
   output logic              tx_dma_odd_o,
   output logic              rx_dma_o,
   output logic              rx_dma_even_o,
   output logic              rx_dma_odd_o,
   output logic              tx_irq_o,
   output logic              rx_irq_o
);
   localparam int MASK_W = 2 * N_SER;

   generate
      if (N_SER < 1)         begin : g_bad_nser  $error("N_SER must be at least 1"); end
      if (SLOT_W < 1)        begin : g_bad_slotw $error("SLOT_W must be at least 1"); end
      if (DATA_W < MASK_W)   begin : g_bad_mask  $error("DATA_W too narrow for masks"); end
      if (DATA_W < SLOT_W)   begin : g_bad_slot  $error("DATA_W too narrow for slot"); end
      if (DATA_W < 4)        begin : g_bad_data  $error("DATA_W must be at least 4"); end
   endgenerate

   logic [N_DIR-1:0]             mode_q;
   logic [3:0]                   ien_q;
   logic [SLOT_W-1:0]            spf_q;
   logic [N_DIR-1:0][N_SER-1:0]  act_q, acc_v, rdy_v;
   logic [N_DIR-1:0]             fire_v, par_v, err_v, clr_v;
   logic [N_DIR-1:0]             ev_all, ev_even, ev_odd;
   logic                         bnd;
   logic [SLOT_W-1:0]            cur_slot, ahead_slot;
   logic                         wdata_unused;

   assign wdata_unused = ^reg_wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ien_q  <= '0;
         spf_q  <= '1;
         act_q  <= '0;
      end else if (reg_wr_i) begin
         case (reg_addr_i)
            RA_CTRL: mode_q <= reg_wdata_i[N_DIR-1:0];
            RA_IEN:  ien_q  <= reg_wdata_i[3:0];
            RA_SPF:  spf_q  <= reg_wdata_i[SLOT_W-1:0];
            RA_MASK: begin
               act_q[DIR_TX] <= reg_wdata_i[N_SER-1:0];
               act_q[DIR_RX] <= reg_wdata_i[N_SER +: N_SER];
            end
            default: ;
         endcase
      end
   end

   assign clr_v[DIR_TX] = reg_wr_i && (reg_addr_i == RA_STAT) && reg_wdata_i[0];
   assign clr_v[DIR_RX] = reg_wr_i && (reg_addr_i == RA_STAT) && reg_wdata_i[1];
   assign acc_v[DIR_TX] = tx_buf_wr_i;
   assign acc_v[DIR_RX] = rx_buf_rd_i;

   tdm_slot_counter #(.SLOT_W(SLOT_W)) i_slot_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .fsync_i (fsync_i),
      .tick_i  (slot_tick_i),
      .spf_i   (spf_q),
      .bnd_o   (bnd),
      .cur_o   (cur_slot),
      .ahead_o (ahead_slot)
   );

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      tdm_dir_tracker #(.N_SER(N_SER), .IS_RX(d)) i_tracker (
         .clk         (clk),
         .rst_n       (rst_n),
         .bnd_i       (bnd),
         .prev_par_i  (cur_slot[0]),
         .ahead_par_i (ahead_slot[0]),
         .act_i       (act_q[d]),
         .acc_i       (acc_v[d]),
         .err_clr_i   (clr_v[d]),
         .fire_o      (fire_v[d]),
         .par_o       (par_v[d]),
         .rdy_o       (rdy_v[d]),
         .err_o       (err_v[d])
      );

      assign ev_all[d]  = fire_v[d] && (mode_q[d] == EV_COMBINED);
      assign ev_even[d] = fire_v[d] && (mode_q[d] == EV_SPLIT) && !par_v[d];
      assign ev_odd[d]  = fire_v[d] && (mode_q[d] == EV_SPLIT) &&  par_v[d];

      assert_one_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({ev_all[d], ev_even[d], ev_odd[d]}));
      assert_combined_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[d] == EV_COMBINED) |-> (!ev_even[d] && !ev_odd[d]));
      assert_split_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[d] == EV_SPLIT) |-> !ev_all[d]);
   end

   assign tx_dma_o      = ev_all[DIR_TX];
   assign tx_dma_even_o = ev_even[DIR_TX];
   assign tx_dma_odd_o  = ev_odd[DIR_TX];
   assign rx_dma_o      = ev_all[DIR_RX];
   assign rx_dma_even_o = ev_even[DIR_RX];
   assign rx_dma_odd_o  = ev_odd[DIR_RX];

   assign tx_irq_o = (ien_q[0] && fire_v[DIR_TX]) || (ien_q[1] && err_v[DIR_TX]);
   assign rx_irq_o = (ien_q[2] && fire_v[DIR_RX]) || (ien_q[3] && err_v[DIR_RX]);

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         RA_CTRL: reg_rdata_o[N_DIR-1:0]      = mode_q;
         RA_IEN:  reg_rdata_o[3:0]            = ien_q;
         RA_SPF:  reg_rdata_o[SLOT_W-1:0]     = spf_q;
         RA_MASK: reg_rdata_o[MASK_W-1:0]     = {act_q[DIR_RX], act_q[DIR_TX]};
         RA_STAT: reg_rdata_o[N_DIR-1:0]      = err_v;
         RA_SLOT: reg_rdata_o[SLOT_W-1:0]     = cur_slot;
         RA_RDY:  reg_rdata_o[MASK_W-1:0]     = {rdy_v[DIR_RX], rdy_v[DIR_TX]};
         default: reg_rdata_o = '0;
      endcase
   end

   assert_no_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> (!tx_irq_o && !rx_irq_o));
endmodule

// File: tb/test_tdm_dma_event_gen.sv
module test_tdm_dma_event_gen;
   import tdm_dma_pkg::*;

   localparam int N_SER  = 3;
   localparam int SLOT_W = 3;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              fsync, tick;
   logic [N_SER-1:0]  tx_wr, rx_rd;
   logic              reg_wr;
   logic [2:0]        reg_addr;
   logic [DATA_W-1:0] reg_wdata, reg_rdata;
   logic              txa, txe, txo, rxa, rxe, rxo, tx_irq, rx_irq;
   logic [5:0]        ev;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   tdm_dma_event_gen #(.N_SER(N_SER), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) i_tdm_dma_event_gen (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .slot_tick_i(tick),
      .tx_buf_wr_i(tx_wr), .rx_buf_rd_i(rx_rd),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .tx_dma_o(txa), .tx_dma_even_o(txe), .tx_dma_odd_o(txo),
      .rx_dma_o(rxa), .rx_dma_even_o(rxe), .rx_dma_odd_o(rxo),
      .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
   );

   assign ev = {txa, txe, txo, rxa, rxe, rxo};

   // {fsync, tick, expected slot[2:0], tx combined, rx even, rx odd}
   localparam logic [7:0] VEC [8] = '{
      8'b10_000_110, 8'b01_001_110, 8'b01_010_101, 8'b01_011_110,
      8'b01_100_101, 8'b01_000_110, 8'b01_001_110, 8'b10_000_101
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = RA_SLOT; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = RA_SLOT;
   endtask

   task automatic step(input logic fs, input logic tk);
      fsync = fs; tick = tk;
      @(negedge clk);
      fsync = 1'b0; tick = 1'b0;
   endtask

   task automatic service();
      tx_wr = '1; rx_rd = '1;
      @(negedge clk);
      tx_wr = '0; rx_rd = '0;
      chk("R3 pulse ends", 32'(ev), 32'd0);
   endtask

   initial begin
      logic [DATA_W-1:0] r;
      rst_n = 1'b0; fsync = 0; tick = 0; tx_wr = '0; rx_rd = '0;
      reg_wr = 0; reg_addr = RA_SLOT; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(RA_SLOT, r); chk("R1 reset slot", 32'(r), 32'd0);
      rd(RA_SPF, r);  chk("R1 reset spf", 32'(r), 32'd7);
      rd(RA_STAT, r); chk("R10 reset status", 32'(r), 32'd0);
      rd(RA_CTRL, r); chk("R4 reset scheme", 32'(r), 32'd0);
      chk("R9 reset irq", {30'd0, tx_irq, rx_irq}, 32'd0);
      chk("R3 reset events", 32'(ev), 32'd0);

      wr(RA_SPF, 16'd5);
      wr(RA_MASK, 16'b101_011);
      wr(RA_CTRL, 16'b10);

      for (int i = 0; i < 8; i++) begin
         step(VEC[i][7], VEC[i][6]);
         chk("R5 R6 R8 table events", 32'(ev), 32'({VEC[i][2], 3'b000, VEC[i][1], VEC[i][0]}));
         rd(RA_SLOT, r);
         chk("R1 table slot", 32'(r), 32'(VEC[i][5:3]));
         service();
      end

      // transmit split, receive combined
      wr(RA_CTRL, 16'b01);
      step(0, 1);
      chk("R5 tx next slot 2 even", 32'(ev), 32'b010_100);
      chk("R8 no irq without enable", {30'd0, tx_irq, rx_irq}, 32'd0);
      service();
      step(0, 1);
      chk("R5 tx next slot 3 odd", 32'(ev), 32'b001_100);
      service();
      step(0, 1); service();
      step(0, 1);
      chk("R5 tx wrap to slot 0 even", 32'(ev), 32'b010_100);
      service();

      wr(RA_IEN, 16'b0101);
      step(0, 1);
      chk("R9 ready irq", {30'd0, tx_irq, rx_irq}, 32'b11);
      service();
      chk("R9 ready irq ends", {30'd0, tx_irq, rx_irq}, 32'd0);

      wr(RA_IEN, 16'b1010);
      step(0, 1);
      chk("R9 no error irq yet", {30'd0, tx_irq, rx_irq}, 32'd0);
      @(negedge clk);
      step(0, 1);
      rd(RA_STAT, r); chk("R10 both errors", 32'(r), 32'd3);
      chk("R9 error irq", {30'd0, tx_irq, rx_irq}, 32'b11);
      wr(RA_STAT, 16'b01);
      rd(RA_STAT, r); chk("R10 clear tx only", 32'(r), 32'd2);
      wr(RA_STAT, 16'b10);
      rd(RA_STAT, r); chk("R10 clear rx", 32'(r), 32'd0);
      service();

      step(0, 1);
      tx_wr = '1; rx_rd = 3'b001;
      @(negedge clk);
      tx_wr = '0; rx_rd = '0;
      rd(RA_RDY, r); chk("R2 partial read leaves flag", 32'(r), 32'h20);
      rx_rd = 3'b100;
      @(negedge clk);
      rx_rd = '0;
      rd(RA_RDY, r); chk("R2 all flags clear", 32'(r), 32'd0);

      wr(RA_MASK, 16'd0);
      step(0, 1);
      chk("R3 empty mask no request", 32'(ev), 32'd0);
      rd(RA_SLOT, r); chk("R1 slot 4", 32'(r), 32'd4);
      rd(RA_STAT, r); chk("R10 no error empty mask", 32'(r), 32'd0);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule